// File: doc/BRIEF.md
# Flash Command Decoder with Status Register

This block is the command front end of a parallel NOR flash device. A bus write carries a command byte in the low eight bits of `wr_data`. The byte selects what a read returns: array contents, the status register, or a two-word device identifier. A command byte can also open a two-write program or erase sequence. The block includes a small erased-at-reset word array, so it can be used on its own. It also includes a programming cycle timer and an erase sequencer. The sequencer rewrites a whole block one word per cycle.

The status register is eight bits wide. Bit 7 is the ready flag. Bit 3 reports that the programming voltage was out of range. Bit 4 reports a program failure and bit 5 an erase failure. The three error bits are sticky. The internal logic can set them, and only the clear-status command resets them. Software can therefore run a series of operations and check for errors once at the end. Bits 0 to 2 and bit 6 always read 0.

Writes have no back-pressure. The block takes every cycle with `wr_en` high as one write. Reads are combinational from `rd_addr`. Programming only clears bits: the new word is the old word AND the written data.

The command codes are 0x40 (program set-up), 0x20 (erase set-up), 0xD0 (erase confirm), 0x70 (read status), 0xFF (read array), 0x90 (read identifier) and 0x50 (clear status). Any other byte written while idle has no effect.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, every array word reads all ones in array mode, and the status register reads 0x80.
- R2: Writing 0xFF selects array reads. Writing 0x70 selects status reads. Writing 0x90 selects identifier reads, which return MFR_ID at an even address and DEV_ID at an odd address.
- R3: Programming is a 0x40 write followed by a write of address and data. It sets the word to old AND data, so writing a 1 over a 0 leaves the 0 in place and sets no error bit.
- R4: Status bit 7 reads 0 for exactly PROG_CYCLES cycles after the program data write, and for exactly 2^BLK_BITS cycles after the erase confirm write. It reads 1 otherwise.
- R5: While a program or erase runs, any write other than 0x70 has no effect. For example, 0xFF written then still leaves reads returning status after completion.
- R6: After a program or erase set-up command, reads return the status register until a 0xFF write selects array reads.
- R7: If vpp_ok is low at the program data write, bit 3 is set, the word is not changed and bit 7 stays 1.
- R8: If fault_inject is high at the program data write, bit 4 is set when the operation completes and the word is not changed.
- R9: A 0x20 write followed by a 0xD0 write erases the block named by the upper address bits of the confirm write. Erase sets all 2^BLK_BITS words of that block to all ones and leaves other blocks unchanged.
- R10: If vpp_ok is low at the erase confirm write, bits 3 and 5 are set, no erase takes place and bit 7 stays 1.
- R11: Any byte other than 0xD0 written after 0x20 aborts the erase and sets bits 4 and 5.
- R12: Bits 3, 4 and 5 stay set across later operations until a 0x50 write clears all three. Bits 0 to 2 and bit 6 always read 0.
- R13: If fault_inject is high at the erase confirm write, bit 5 is set when the erase completes and the block is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low byte carries the command |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data selected by the current read mode |
| vpp_ok | input | 1 | Programming voltage within range |
| fault_inject | input | 1 | Forces the current program or erase to fail its verify |

## Verification
A command write takes effect at the clock edge that samples it, so mode changes and immediate error bits show one cycle later. Reads are combinational, and the bench samples them at the falling edge after that write. For a program, the bench samples the ready flag right after the data write. It samples again after PROG_CYCLES-1 further edges, when the flag must still be 0. It samples once more one edge later, when the flag must be 1. Erase timing is checked the same way over 2^BLK_BITS edges. A bench model of the array and of the sticky bits supplies every expected value.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rd_mode_e;
  typedef enum logic [2:0] {CS_IDLE, CS_PSET, CS_ESET, CS_PBUSY, CS_EBUSY} cmd_state_e;

  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_RDSR    = 8'h70;
  localparam logic [7:0] OP_RDARR   = 8'hFF;
  localparam logic [7:0] OP_RDID    = 8'h90;
  localparam logic [7:0] OP_CLRSR   = 8'h50;
endpackage

// File: rtl/fcd_array.sv
module fcd_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwe,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pdata,
  input  logic              ewe,
  input  logic [ADDR_W-1:0] eaddr,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_word;

  assign old_word = mem[paddr];
  assign rdata    = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (pwe) begin
      mem[paddr] <= old_word & pdata;
    end else if (ewe) begin
      mem[eaddr] <= '1;
    end
  end

  // R3
  prog_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwe |=> ((mem[$past(paddr)] & ~$past(old_word)) == '0));

  // R9
  erase_sets_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ewe && !pwe) |=> (mem[$past(eaddr)] == '1));
endmodule

// File: rtl/fcd_prog_timer.sv
module fcd_prog_timer #(
  parameter int PROG_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  // R4
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == CW'(PROG_CYCLES)));
endmodule

// File: rtl/fcd_erase_seq.sv
module fcd_erase_seq #(
  parameter int ADDR_W   = 6,
  parameter int BLK_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-BLK_BITS-1:0] blk,
  input  logic                       fault,
  output logic                       we,
  output logic [ADDR_W-1:0]          waddr,
  output logic                       done,
  output logic                       failed
);
  logic                       active;
  logic                       flt_q;
  logic [BLK_BITS-1:0]        idx;
  logic [ADDR_W-BLK_BITS-1:0] blk_q;

  assign we     = active && !flt_q;
  assign waddr  = {blk_q, idx};
  assign done   = active && (idx == '1);
  assign failed = done && flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      flt_q  <= 1'b0;
      idx    <= '0;
      blk_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      flt_q  <= fault;
      idx    <= '0;
      blk_q  <= blk;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == '1) active <= 1'b0;
    end
  end

  // R4
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && idx == '0));

  // R4
  erase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !active);
endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int BLK_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       vpp_ok,
  input  logic                       fault_inject,
  input  logic                       prog_done,
  input  logic                       erase_done,
  input  logic                       erase_failed,
  output rd_mode_e                   mode,
  output logic [7:0]                 status,
  output logic                       prog_start,
  output logic                       erase_start,
  output logic [ADDR_W-BLK_BITS-1:0] erase_blk,
  output logic                       erase_fault,
  output logic                       pwe,
  output logic [ADDR_W-1:0]          paddr,
  output logic [DATA_W-1:0]          pdata
);
  cmd_state_e        state;
  logic              st_ready, st_vpp, st_perr, st_eerr;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_data_q;
  logic              p_flt_q;
  logic [7:0]        cmd;
  logic              clr_hit;

  assign cmd         = wr_data[7:0];
  assign status      = {st_ready, 1'b0, st_eerr, st_perr, st_vpp, 3'b000};
  assign prog_start  = wr_en && (state == CS_PSET) && vpp_ok;
  assign erase_start = wr_en && (state == CS_ESET) && (cmd == OP_CONFIRM) && vpp_ok;
  assign erase_blk   = wr_addr[ADDR_W-1:BLK_BITS];
  assign erase_fault = fault_inject;
  assign pwe         = prog_done && !p_flt_q;
  assign paddr       = p_addr_q;
  assign pdata       = p_data_q;
  assign clr_hit     = wr_en && (state == CS_IDLE) && (cmd == OP_CLRSR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      mode     <= RM_ARRAY;
      st_ready <= 1'b1;
      st_vpp   <= 1'b0;
      st_perr  <= 1'b0;
      st_eerr  <= 1'b0;
      p_addr_q <= '0;
      p_data_q <= '0;
      p_flt_q  <= 1'b0;
    end else begin
      case (state)
        CS_IDLE: if (wr_en) begin
          case (cmd)
            OP_PROG:  begin state <= CS_PSET; mode <= RM_STATUS; end
            OP_ERASE: begin state <= CS_ESET; mode <= RM_STATUS; end
            OP_RDSR:  mode <= RM_STATUS;
            OP_RDARR: mode <= RM_ARRAY;
            OP_RDID:  mode <= RM_IDENT;
            OP_CLRSR: begin st_vpp <= 1'b0; st_perr <= 1'b0; st_eerr <= 1'b0; end
            default:  ;
          endcase
        end
        CS_PSET: if (wr_en) begin
          if (vpp_ok) begin
            state    <= CS_PBUSY;
            st_ready <= 1'b0;
            p_addr_q <= wr_addr;
            p_data_q <= wr_data;
            p_flt_q  <= fault_inject;
          end else begin
            st_vpp <= 1'b1;
            state  <= CS_IDLE;
          end
        end
        CS_ESET: if (wr_en) begin
          if (cmd == OP_CONFIRM) begin
            if (vpp_ok) begin
              state    <= CS_EBUSY;
              st_ready <= 1'b0;
            end else begin
              st_vpp  <= 1'b1;
              st_eerr <= 1'b1;
              state   <= CS_IDLE;
            end
          end else begin
            st_perr <= 1'b1;
            st_eerr <= 1'b1;
            state   <= CS_IDLE;
          end
        end
        CS_PBUSY: begin
          if (wr_en && cmd == OP_RDSR) mode <= RM_STATUS;
          if (prog_done) begin
            st_ready <= 1'b1;
            state    <= CS_IDLE;
            if (p_flt_q) st_perr <= 1'b1;
          end
        end
        CS_EBUSY: begin
          if (wr_en && cmd == OP_RDSR) mode <= RM_STATUS;
          if (erase_done) begin
            st_ready <= 1'b1;
            state    <= CS_IDLE;
            if (erase_failed) st_eerr <= 1'b1;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_vpp) || $fell(st_perr) || $fell(st_eerr)) |-> $past(clr_hit));

  // R7
  vpp_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state == CS_PSET && !vpp_ok) |=> (st_vpp && st_ready));

  // R4
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |=> !st_ready);

  // R5
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CS_PBUSY || state == CS_EBUSY) && !(wr_en && cmd == OP_RDSR))
      |=> $stable(mode));

  // R11
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state == CS_ESET && cmd != OP_CONFIRM) |=> (st_perr && st_eerr && st_ready));
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import fcd_pkg::*;
#(
  parameter int              ADDR_W      = 6,
  parameter int              DATA_W      = 8,
  parameter int              BLK_BITS    = 4,
  parameter int              PROG_CYCLES = 5,
  parameter logic [DATA_W-1:0] MFR_ID    = DATA_W'(8'h5A),
  parameter logic [DATA_W-1:0] DEV_ID    = DATA_W'(8'hC3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vpp_ok,
  input  logic              fault_inject
);
  localparam int BLK_IDX_W = ADDR_W - BLK_BITS;

  rd_mode_e               mode;
  logic [7:0]             status;
  logic                   prog_start, prog_done;
  logic                   erase_start, erase_done, erase_failed, erase_fault;
  logic [BLK_IDX_W-1:0]   erase_blk;
  logic                   pwe, ewe;
  logic [ADDR_W-1:0]      paddr, eaddr;
  logic [DATA_W-1:0]      pdata, arr_q;

  fcd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BITS(BLK_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .fault_inject(fault_inject), .prog_done(prog_done),
    .erase_done(erase_done), .erase_failed(erase_failed), .mode(mode), .status(status),
    .prog_start(prog_start), .erase_start(erase_start), .erase_blk(erase_blk),
    .erase_fault(erase_fault), .pwe(pwe), .paddr(paddr), .pdata(pdata)
  );

  fcd_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .done(prog_done)
  );

  fcd_erase_seq #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .blk(erase_blk), .fault(erase_fault),
    .we(ewe), .waddr(eaddr), .done(erase_done), .failed(erase_failed)
  );

  fcd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .pwe(pwe), .paddr(paddr), .pdata(pdata),
    .ewe(ewe), .eaddr(eaddr), .raddr(rd_addr), .rdata(arr_q)
  );

  always_comb begin
    case (mode)
      RM_STATUS: rd_data = DATA_W'(status);
      RM_IDENT:  rd_data = rd_addr[0] ? DEV_ID : MFR_ID;
      default:   rd_data = arr_q;
    endcase
  end
endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int BB = 4;
  localparam int PC = 5;
  localparam int NW = 1 << AW;
  localparam int NB = 1 << BB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic vpp_ok = 1'b1;
  logic fault_inject = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [NW];
  bit e_vpp = 0, e_perr = 0, e_eerr = 0;

  always #10 clk = ~clk;

  flash_cmd_front #(.ADDR_W(AW), .DATA_W(DW), .BLK_BITS(BB), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vpp_ok(vpp_ok), .fault_inject(fault_inject)
  );

  function automatic logic [7:0] exp_status(input bit ready);
    return {ready, 1'b0, e_eerr, e_perr, e_vpp, 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // program through the two-write sequence, checking busy window and status
  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input bit vpp, input bit flt);
    logic [DW-1:0] q;
    wr(a, 8'h40);
    vpp_ok = vpp; fault_inject = flt;
    wr(a, d);
    vpp_ok = 1'b1; fault_inject = 1'b0;
    if (!vpp) begin
      e_vpp = 1;
      rd(a, q); chk("R7 vpp fault status", q, exp_status(1));
    end else begin
      rd(a, q); chk("R4 program busy start", q[7], 1'b0);
      repeat (PC - 1) @(negedge clk);
      rd(a, q); chk("R4 program busy last", q[7], 1'b0);
      @(negedge clk);
      if (flt) e_perr = 1;
      else model[a] = model[a] & d;
      rd(a, q); chk("R3 R8 program done status", q, exp_status(1));
    end
  endtask

  task automatic do_erase(input logic [AW-BB-1:0] b, input bit vpp, input bit flt);
    logic [DW-1:0] q;
    wr({b, BB'(0)}, 8'h20);
    vpp_ok = vpp; fault_inject = flt;
    wr({b, BB'(0)}, 8'hD0);
    vpp_ok = 1'b1; fault_inject = 1'b0;
    if (!vpp) begin
      e_vpp = 1; e_eerr = 1;
      rd('0, q); chk("R10 erase vpp status", q, exp_status(1));
    end else begin
      rd('0, q); chk("R4 erase busy start", q[7], 1'b0);
      repeat (NB - 1) @(negedge clk);
      rd('0, q); chk("R4 erase busy last", q[7], 1'b0);
      @(negedge clk);
      if (flt) e_eerr = 1;
      else for (int i = 0; i < NB; i++) model[{b, BB'(i)}] = '1;
      rd('0, q); chk("R9 R13 erase done status", q, exp_status(1));
    end
  endtask

  task automatic check_array(input string tag);
    logic [DW-1:0] q;
    wr('0, 8'hFF);
    for (int i = 0; i < NW; i++) begin
      rd(AW'(i), q); chk(tag, q, model[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] q;
    void'($urandom(32'd24681));
    for (int i = 0; i < NW; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd0, q); chk("R1 array after reset", q, 8'hFF);
    rd(6'd63, q); chk("R1 array after reset top", q, 8'hFF);
    wr('0, 8'h70);
    rd('0, q); chk("R1 R2 status after reset", q, 8'h80);

    // R2 identifier and array modes
    wr('0, 8'h90);
    rd(6'd0, q); chk("R2 maker id", q, 8'h5A);
    rd(6'd1, q); chk("R2 device id", q, 8'hC3);
    wr('0, 8'h12);
    rd(6'd2, q); chk("R2 unknown byte keeps id mode", q, 8'h5A);
    wr('0, 8'hFF);
    rd(6'd1, q); chk("R2 array mode", q, 8'hFF);

    // R3 R4 program, R6 status persists
    do_prog(6'd5, 8'h3C, 1, 0);
    rd(6'd5, q); chk("R6 reads status before read array", q, 8'h80);
    wr('0, 8'hFF);
    rd(6'd5, q); chk("R3 programmed word", q, 8'h3C);
    do_prog(6'd5, 8'hF0, 1, 0);
    wr('0, 8'hFF);
    rd(6'd5, q); chk("R3 ones do not restore bits", q, 8'h30);

    // R5 commands ignored while busy
    wr(6'd7, 8'h40);
    wr(6'd7, 8'h0F);
    model[7] = 8'h0F;
    wr('0, 8'hFF);
    wr('0, 8'h90);
    repeat (PC) @(negedge clk);
    rd(6'd7, q); chk("R5 busy writes ignored", q, 8'h80);
    wr('0, 8'hFF);
    rd(6'd7, q); chk("R5 program still done", q, 8'h0F);

    // R7 voltage fault, R8 verify fault, R12 sticky
    do_prog(6'd9, 8'h00, 0, 0);
    do_prog(6'd10, 8'h00, 1, 1);
    rd('0, q); chk("R12 sticky bits 3 and 4", q, 8'h98);
    do_prog(6'd20, 8'h55, 1, 0);
    rd('0, q); chk("R12 bits survive good program", q, 8'h98);
    wr('0, 8'hFF);
    rd(6'd9, q); chk("R7 word unchanged", q, 8'hFF);
    rd(6'd10, q); chk("R8 word unchanged", q, 8'hFF);
    wr('0, 8'h50);
    e_vpp = 0; e_perr = 0;
    wr('0, 8'h70);
    rd('0, q); chk("R12 clear status", q, 8'h80);

    // R9 erase block 0, block 1 untouched
    do_erase(2'd0, 1, 0);
    wr('0, 8'hFF);
    rd(6'd5, q); chk("R9 erased word", q, 8'hFF);
    rd(6'd20, q); chk("R9 other block kept", q, 8'h55);

    // R10 erase voltage fault
    do_erase(2'd1, 0, 0);
    wr('0, 8'hFF);
    rd(6'd20, q); chk("R10 block not erased", q, 8'h55);
    wr('0, 8'h50); e_vpp = 0; e_eerr = 0;

    // R11 sequence error
    wr(6'd16, 8'h20);
    wr(6'd16, 8'h70);
    e_perr = 1; e_eerr = 1;
    rd('0, q); chk("R11 sequence error", q, 8'hB0);
    wr('0, 8'hFF);
    rd(6'd20, q); chk("R11 no erase", q, 8'h55);
    wr('0, 8'h50); e_perr = 0; e_eerr = 0;

    // R13 erase verify fault
    do_erase(2'd1, 1, 1);
    rd('0, q); chk("R13 erase fail bit", q, 8'hA0);
    wr('0, 8'hFF);
    rd(6'd20, q); chk("R13 block unchanged", q, 8'h55);
    wr('0, 8'h50); e_eerr = 0;

    // random mix
    for (int n = 0; n < 60; n++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0) do_erase(2'($urandom), 1, 0);
      else if (r == 1) do_prog(6'($urandom), 8'($urandom), 0, 0);
      else if (r == 2) do_prog(6'($urandom), 8'($urandom), 1, 1);
      else if (r == 3) begin
        wr('0, 8'h50); e_vpp = 0; e_perr = 0; e_eerr = 0;
        wr('0, 8'h70);
        rd('0, q); chk("R12 random clear", q, exp_status(1));
      end else do_prog(6'($urandom), 8'($urandom), 1, 0);
    end
    check_array("R3 R9 random readback");
    wr('0, 8'h70);
    rd('0, q); chk("R12 final status", q, exp_status(1));

    finish_run();
  end
endmodule